// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs single external memory transfers over a bus where the same 16 lines carry the address first and the data after. A requester presents a 22-bit address, 16 bits of write data and a direction flag. The controller accepts the request only while it is idle. It then sequences one address state, one data state, any number of wait states and one final data state. After that it returns a one-cycle completion pulse and, for reads, the captured data.

The low 16 address bits share the data lines and appear only in the address state. The upper 6 bits sit on their own dedicated lines and are held for the whole transfer. The shared lines are driven through a separate output-enable, so pad tristate logic outside the block can float them. They float when the bus is idle and while the external device returns read data. An external ready input, sampled at the end of each data or wait state, stretches the cycle. All outputs come from registers that change on the rising clock edge.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, `ad_oe`=0, `ale`=0, `rd_stb`=0, `wr_stb`=0, `done`=0, `rdata`=0.
- R2: A request sampled with `req_valid`=1 at a clock edge while `req_ready`=1 starts an address state in the next cycle. In that state `ale`=1, `ad_oe`=1, `ad_out`=`req_addr[15:0]`, `a_hi`=`req_addr[21:16]` and `req_ready`=0.
- R3: The address state lasts exactly one cycle. The next cycle is the first data state: `ale`=0 and the direction strobe (`rd_stb` for reads, `wr_stb` for writes) is 1.
- R4: `bus_ready` is sampled at the end of the first data state and of each wait state. Each low sample adds one more wait cycle. A high sample moves the cycle to the final data state. The direction strobe therefore stays high for 2+N cycles, where N is the number of low samples.
- R5: In a write, `ad_oe`=1 and `ad_out` equals the latched write data in every cycle that `wr_stb` is high.
- R6: In a read, `ad_oe`=0 while `rd_stb` is high. `rdata` takes the value of `ad_in` sampled at the edge that ends the final data state. Values on `ad_in` in earlier data states have no effect.
- R7: `done` is 1 for exactly the one cycle after the final data state. In that cycle the strobes and `ad_oe` are 0 and `req_ready`=1.
- R8: A `req_valid` asserted while a transfer is in progress is ignored. No new address state follows, and `a_hi` keeps the accepted address until the transfer ends.
- R9: `rdata` changes only when a read completes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle, request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read data |
| ad_out | output | 16 | Shared address/data lines, output value |
| ad_in | input | 16 | Shared address/data lines, input value |
| ad_oe | output | 1 | Output enable for the shared lines |
| a_hi | output | 6 | Dedicated upper address lines |
| ale | output | 1 | Address strobe, high in the address state |
| rd_stb | output | 1 | Read strobe, high through the data and wait states |
| wr_stb | output | 1 | Write strobe, high through the data and wait states |
| bus_ready | input | 1 | External ready, low requests wait states |

## Verification
Counting from the edge that samples a request, the address state is visible one cycle later and the first data state two cycles later. Each low sample of `bus_ready` then pushes the final data state and `done` out by one more cycle. With N waits, `done` and the new `rdata` appear 4+N cycles after the accepting edge. The bench drives inputs on falling edges and steps through the transfer one falling edge at a time. At each step it checks the phase it expects, so any extra or missing state shows up as a mismatch in that cycle. The sweep covers both directions, wait counts 0 to 5 and several address/data patterns. It puts decoy values on `ad_in` before the final data state and raises stray requests mid-transfer.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [DATA_W-1:0]        ad_out,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ale,
  output logic                     rd_stb,
  output logic                     wr_stb,
  input  logic                     bus_ready
);
  localparam int HI_W = ADDR_W - DATA_W;

  typedef enum logic [2:0] {S_IDLE, S_ADR, S_DAT, S_WAIT, S_END} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          write_q <= req_write;
          st      <= S_ADR;
        end
        S_ADR:  st <= S_DAT;
        S_DAT,
        S_WAIT: st <= bus_ready ? S_END : S_WAIT;
        S_END: begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          if (!write_q) rdata_q <= ad_in;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_data   = (st == S_DAT) || (st == S_WAIT) || (st == S_END);
  assign req_ready = (st == S_IDLE);
  assign ale       = (st == S_ADR);
  assign rd_stb    = in_data && !write_q;
  assign wr_stb    = in_data && write_q;
  assign ad_oe     = ale || wr_stb;
  assign ad_out    = ale ? addr_q[DATA_W-1:0] : wdata_q;
  assign a_hi      = addr_q[ADDR_W-1:DATA_W];
  assign done      = done_q;
  assign rdata     = rdata_q;

  // R1
  idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ad_oe);

  // R2
  addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe && !req_ready);

  // R3
  addr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale && (rd_stb || wr_stb));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ale, rd_stb, wr_stb}));

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && $past(wr_stb) |-> $stable(ad_out) && ad_oe);

  // R6
  read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !ad_oe);

  // R7
  done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_stb || wr_stb) && !rd_stb && !wr_stb && req_ready);

  // R8
  hi_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> $stable(a_hi));

  // R9
  rdata_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(wr_stb) |-> $stable(rdata));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: tb/test_mux_bus_ctrl.sv
`timescale 1ns/1ps
module test_mux_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic        done;
  logic [15:0] rdata;
  logic [15:0] ad_out;
  logic [15:0] ad_in = '0;
  logic        ad_oe;
  logic [5:0]  a_hi;
  logic        ale;
  logic        rd_stb;
  logic        wr_stb;
  logic        bus_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [15:0] last_rd = '0;

  always #2 clk = ~clk;

  mux_bus_ctrl i_mux_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
    .a_hi(a_hi), .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_ready(bus_ready));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic xfer(input logic wr, input logic [21:0] adr, input logic [15:0] wd,
                      input int nwait, input logic [15:0] rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = adr; req_wdata = wd;
    bus_ready = 1'b1; ad_in = ~rv;
    @(negedge clk);
    req_valid = 1'b0; req_write = ~wr; req_addr = ~adr; req_wdata = ~wd;
    chk(ale && ad_oe && !req_ready, "R2 addr state ale/oe/busy", {ale, ad_oe, req_ready}, 3'b110);
    chk(ad_out == adr[15:0], "R2 low address on AD", ad_out, adr[15:0]);
    chk(a_hi == adr[21:16], "R2 upper address", a_hi, adr[21:16]);
    for (int i = 0; i <= nwait; i++) begin
      @(negedge clk);
      bus_ready = (i == nwait);
      if (i == 1) begin req_valid = 1'b1; req_addr = 22'h2AAAAA; end
      chk(!ale && (wr ? (wr_stb && !rd_stb) : (rd_stb && !wr_stb)),
          i == 0 ? "R3 first data state strobe" : "R4 wait state strobe",
          {ale, rd_stb, wr_stb}, {1'b0, !wr, wr});
      chk(ad_oe == wr, wr ? "R5 write drives AD" : "R6 read floats AD", ad_oe, wr);
      if (wr) chk(ad_out == wd, "R5 write data on AD", ad_out, wd);
      chk(a_hi == adr[21:16], "R8 upper address held", a_hi, adr[21:16]);
      chk(!done, "R7 no early done", done, 1'b0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    bus_ready = 1'b1;
    ad_in = rv;
    chk(wr ? wr_stb : rd_stb, "R4 final data state after ready", {rd_stb, wr_stb}, {!wr, wr});
    chk(ad_oe == wr, "R5/R6 oe in final data state", ad_oe, wr);
    chk(!ale, "R8 busy request ignored", ale, 1'b0);
    @(negedge clk);
    ad_in = 16'h0;
    chk(done && !rd_stb && !wr_stb && !ad_oe && req_ready, "R7 done cycle",
        {done, rd_stb, wr_stb, ad_oe, req_ready}, 5'b10001);
    if (!wr) last_rd = rv;
    chk(rdata == last_rd, wr ? "R9 write keeps rdata" : "R6 read capture", rdata, last_rd);
    @(negedge clk);
    chk(!done && !ale && !ad_oe, "R7 one-cycle done, R8 no stray start",
        {done, ale, ad_oe}, 3'b000);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5;
    chk(req_ready && !ad_oe && !ale && !rd_stb && !wr_stb && !done && rdata == 0,
        "R1 reset state", {req_ready, ad_oe, ale, rd_stb, wr_stb, done}, 6'b100000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !ad_oe, "R1 idle after reset", {req_ready, ad_oe}, 2'b10);
    for (int a = 0; a < 3; a++) begin
      for (int n = 0; n < 6; n++) begin
        for (int w = 0; w < 2; w++) begin
          logic [21:0] adr;
          logic [15:0] d;
          adr = (a == 0) ? 22'h3FFFFF : (a == 1) ? 22'h000000 : 22'h15A5C3 + 22'(n * 4099);
          d   = 16'(16'hC3A5 ^ (n * 257) ^ (a * 4660) ^ (w * 43690));
          xfer(w[0], adr, d, n, ~d + 16'(n));
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule